// File: doc/BRIEF.md
# Direct-Mapped Cache Address Invalidate Unit

This block keeps the tag, valid and dirty state of a direct-mapped data cache and performs one maintenance action on it: invalidating a line by address, and only when that line holds the addressed data. A request carries a base value and a signed 16-bit offset. The unit adds the sign-extended offset to the base to form the effective address and splits that address into a tag and a line index. It then clears the indexed line if the line is valid and its stored tag equals the address tag. Dirty contents are thrown away without any write-back.

A fill port preloads the tag, valid and dirty state of any line. A registered probe port reads back the state of a line. A build-time parameter can remove the cache entirely. In that case every request still completes, but it never reports a hit.

Top module: `dcl_addr_invalidate`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to ADDR_W bits, modulo 2^ADDR_W. A negative offset such as -100 yields a lower address.
- R2: The lowest log2(LINE_BYTES) bits of the effective address are a byte offset and play no part in the lookup. The next log2(NUM_LINES) bits are the line index. The remaining upper bits are the tag.
- R3: If the indexed line's stored tag differs from the address tag, the request reports no hit and leaves all valid, dirty and tag state unchanged.
- R4: A line whose valid bit is clear counts as a miss, even when its stored tag matches.
- R5: On a hit, the line's valid bit and dirty bit are both cleared and `hit` is 1. The outcome does not depend on the dirty bit.
- R6: A request is accepted at the rising edge where `req_valid` is 1. `done` is 0 after that edge. `done` and `hit` are 1 for exactly one cycle after the following edge.
- R7: With HAS_CACHE = 0, every request still produces `done` with the same timing, and `hit` stays 0.
- R8: A fill sets the tag, valid and dirty state of `fill_idx` at the edge where `fill_en` is 1. A request accepted at that same edge sees the filled state.
- R9: Suppose an invalidation clears a line at the same edge where a fill targets that line. The line's valid and dirty bits end cleared, and the tag takes the fill value.
- R10: A synchronous active-high reset clears every valid and dirty bit, as well as `done` and `hit`.
- R11: The probe outputs show the tag, valid and dirty state of `probe_idx` as it stood before the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Invalidate request strobe |
| req_base | input | ADDR_W | Base address operand |
| req_imm | input | 16 | Signed offset operand |
| done | output | 1 | Request completed (one cycle) |
| hit | output | 1 | Completed request invalidated a line |
| fill_en | input | 1 | Line state write strobe |
| fill_idx | input | IDX_W | Line written by fill |
| fill_tag | input | TAG_W | Tag written by fill |
| fill_valid | input | 1 | Valid bit written by fill |
| fill_dirty | input | 1 | Dirty bit written by fill |
| probe_idx | input | IDX_W | Line to read back |
| probe_tag | output | TAG_W | Stored tag of probed line |
| probe_valid | output | 1 | Valid bit of probed line |
| probe_dirty | output | 1 | Dirty bit of probed line |

## Verification
The outcome of a request is due two edges after the request is accepted. The bench drives inputs on falling edges and samples on falling edges. It checks that `done` is still 0 one falling edge after the request and that `done` and `hit` are correct one falling edge after that. A probe result is due one edge after `probe_idx` is set, so the bench reads it at the following falling edge. Because of this, any state change caused by a request is read back at least one cycle after the request completes. For the fill-collision cases, the fill is driven in the exact cycle that makes it coincide with the request's lookup edge or with its clearing edge.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int IMM_W = 16;

  typedef enum logic [1:0] {
    LR_IDLE = 2'd0,
    LR_MISS = 2'd1,
    LR_HIT  = 2'd2
  } lookup_res_e;
endpackage

// File: rtl/dcl_ea_split.sv
module dcl_ea_split #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFS_W  = 5,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] imm_sx;
  logic [ADDR_W-1:0] ea;
  logic              ofs_unused;

  assign imm_sx     = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign ea         = base + imm_sx;
  assign idx        = ea[OFS_W +: IDX_W];
  assign tag        = ea[ADDR_W-1 -: TAG_W];
  assign ofs_unused = ^ea[OFS_W-1:0];
endmodule

// File: rtl/dcl_tag_ram.sv
module dcl_tag_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 23,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/dcl_line_state.sv
module dcl_line_state #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inv_en,
  input  logic [IDX_W-1:0]     inv_idx,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic                 fill_valid,
  input  logic                 fill_dirty,
  output logic [NUM_LINES-1:0] valid_q,
  output logic [NUM_LINES-1:0] dirty_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic kill, load;
    assign kill = inv_en && (inv_idx == IDX_W'(i));
    assign load = fill_en && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (kill) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (load) begin
        valid_q[i] <= fill_valid;
        dirty_q[i] <= fill_dirty;
      end
    end
  end

  a_r5_valid_cleared: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !valid_q[$past(inv_idx)]);
  a_r5_dirty_dropped: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !dirty_q[$past(inv_idx)]);
  a_r3_quiet_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (!inv_en && !fill_en) |=> ($stable(valid_q) && $stable(dirty_q)));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (valid_q == '0 && dirty_q == '0));
endmodule

// File: rtl/dcl_addr_invalidate.sv
module dcl_addr_invalidate
  import dcl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int LINE_BYTES = 32,
  parameter bit HAS_CACHE  = 1'b1,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IMM_W-1:0]  req_imm,
  output logic              done,
  output logic              hit,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_valid,
  input  logic              fill_dirty,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [TAG_W-1:0]  probe_tag,
  output logic              probe_valid,
  output logic              probe_dirty
);
  logic [TAG_W-1:0] ea_tag;
  logic [IDX_W-1:0] ea_idx;

  dcl_ea_split #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
  ) u_split (
    .base(req_base), .imm(req_imm), .tag(ea_tag), .idx(ea_idx)
  );

  // Lookup stage: request fields captured alongside the tag RAM read.
  logic             p_vld, p_fwd;
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag, p_fwd_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld <= 1'b0;
      p_fwd <= 1'b0;
    end else begin
      p_vld <= req_valid;
      p_fwd <= req_valid && fill_en && (fill_idx == ea_idx);
    end
    p_idx     <= ea_idx;
    p_tag     <= ea_tag;
    p_fwd_tag <= fill_tag;
  end

  logic hit_now;

  if (HAS_CACHE) begin : g_cache
    logic [TAG_W-1:0]     stored_tag;
    logic [TAG_W-1:0]     cmp_tag;
    logic [NUM_LINES-1:0] vvec, dvec;
    logic                 inv_en;

    dcl_tag_ram #(.DEPTH(NUM_LINES), .WIDTH(TAG_W)) u_tags (
      .clk(clk), .we(fill_en), .waddr(fill_idx), .wdata(fill_tag),
      .ra_addr(ea_idx), .ra_data(stored_tag),
      .rb_addr(probe_idx), .rb_data(probe_tag)
    );

    assign cmp_tag = p_fwd ? p_fwd_tag : stored_tag;
    assign inv_en  = p_vld && vvec[p_idx] && (cmp_tag == p_tag);
    assign hit_now = inv_en;

    dcl_line_state #(.NUM_LINES(NUM_LINES)) u_state (
      .clk(clk), .rst(rst),
      .inv_en(inv_en), .inv_idx(p_idx),
      .fill_en(fill_en), .fill_idx(fill_idx),
      .fill_valid(fill_valid), .fill_dirty(fill_dirty),
      .valid_q(vvec), .dirty_q(dvec)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        probe_valid <= 1'b0;
        probe_dirty <= 1'b0;
      end else begin
        probe_valid <= vvec[probe_idx];
        probe_dirty <= dvec[probe_idx];
      end
    end

    a_r4_hit_needs_valid_line: assert property (@(posedge clk) disable iff (rst)
      hit_now |-> vvec[p_idx]);
  end else begin : g_none
    assign hit_now     = 1'b0;
    assign probe_tag   = '0;
    assign probe_valid = 1'b0;
    assign probe_dirty = 1'b0;

    a_r7_never_hits: assert property (@(posedge clk) disable iff (rst) !hit);
  end

  lookup_res_e res_q;

  always_ff @(posedge clk) begin
    if (rst)          res_q <= LR_IDLE;
    else if (!p_vld)  res_q <= LR_IDLE;
    else if (hit_now) res_q <= LR_HIT;
    else              res_q <= LR_MISS;
  end

  assign done = (res_q != LR_IDLE);
  assign hit  = (res_q == LR_HIT);

  a_r6_done_two_edges: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 done);
  a_r6_hit_implies_done: assert property (@(posedge clk) disable iff (rst)
    hit |-> done);
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (rst)
    !p_vld |=> !done);
endmodule

// File: tb/sim_dcl_addr_invalidate.sv
`timescale 1ns/1ps
module sim_dcl_addr_invalidate;
  localparam int AW = 32, NL = 16, LB = 32, IW = 4, TW = 23;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic fill_en = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
  logic [IW-1:0] fill_idx = '0, probe_idx = '0;
  logic [TW-1:0] fill_tag = '0;
  logic done, hit, probe_valid, probe_dirty;
  logic [TW-1:0] probe_tag;
  logic done1, hit1, pv1, pd1;
  logic [TW-1:0] pt1;

  always #2 clk = ~clk;

  dcl_addr_invalidate #(.ADDR_W(AW), .NUM_LINES(NL), .LINE_BYTES(LB), .HAS_CACHE(1'b1)) u0 (
    .clk, .rst, .req_valid, .req_base, .req_imm, .done, .hit,
    .fill_en, .fill_idx, .fill_tag, .fill_valid, .fill_dirty,
    .probe_idx, .probe_tag, .probe_valid, .probe_dirty);

  dcl_addr_invalidate #(.ADDR_W(AW), .NUM_LINES(NL), .LINE_BYTES(LB), .HAS_CACHE(1'b0)) u1 (
    .clk, .rst, .req_valid, .req_base, .req_imm, .done(done1), .hit(hit1),
    .fill_en, .fill_idx, .fill_tag, .fill_valid, .fill_dirty,
    .probe_idx, .probe_tag(pt1), .probe_valid(pv1), .probe_dirty(pd1));

  logic [TW-1:0] m_tag [NL];
  bit m_v [NL], m_d [NL], m_set [NL];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(string rq, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", rq, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] ea_of(logic [AW-1:0] b, logic [15:0] im);
    return b + AW'(int'($signed(im)));
  endfunction

  task automatic do_fill(int i, logic [TW-1:0] t, bit v, bit d);
    fill_en = 1'b1; fill_idx = IW'(i); fill_tag = t; fill_valid = v; fill_dirty = d;
    @(negedge clk);
    fill_en = 1'b0;
    m_tag[i] = t; m_v[i] = v; m_d[i] = d; m_set[i] = 1'b1;
  endtask

  task automatic probe_chk(int i, string rq);
    probe_idx = IW'(i);
    @(negedge clk);
    check({rq, " valid"}, probe_valid, m_v[i]);
    check({rq, " dirty"}, probe_dirty, m_d[i]);
    if (m_set[i]) check({rq, " tag"}, probe_tag, m_tag[i]);
  endtask

  // Request, then check done/hit per R6 timing; model updated on hit.
  task automatic inval(logic [AW-1:0] b, logic [15:0] im, string rq);
    logic [AW-1:0] ea;
    int i;
    logic [TW-1:0] t;
    bit eh;
    ea = ea_of(b, im);
    i = int'((ea / LB) % NL);
    t = TW'(ea / (LB * NL));
    eh = m_v[i] && (m_tag[i] == t);
    req_valid = 1'b1; req_base = b; req_imm = im;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 done early", done, 0);
    @(negedge clk);
    check("R6 done", done, 1);
    check(rq, hit, eh);
    check("R7 done", done1, 1);
    check("R7 hit", hit1, 0);
    if (eh) begin m_v[i] = 1'b0; m_d[i] = 1'b0; end
  endtask

  function automatic logic [AW-1:0] addr_of(logic [TW-1:0] t, int i, int ofs);
    return AW'(t) * (LB * NL) + AW'(i * LB + ofs);
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [6];
    imms = '{16'hFF9C, 16'h0000, 16'h0064, 16'h8000, 16'h7FFF, 16'h0001};
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_d[i] = 0; m_set[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    check("R10 done", done, 0);
    check("R10 hit", hit, 0);
    rst = 1'b0;
    for (int i = 0; i < NL; i++) probe_chk(i, "R10 after reset");

    // R8: preload every line with a mix of valid/dirty.
    for (int i = 0; i < NL; i++) do_fill(i, TW'(i * 37 + 5), (i % 4) != 3, i[0]);
    for (int i = 0; i < NL; i++) probe_chk(i, "R8 fill");

    // R3: wrong tag at every index never changes state.
    for (int i = 0; i < NL; i++) begin
      logic [AW-1:0] ea;
      ea = addr_of(m_tag[i] ^ TW'(1), i, (i * 7) % LB);
      inval(ea - AW'(int'($signed(imms[i % 6]))), imms[i % 6], "R3 miss");
      probe_chk(i, "R3 unchanged");
    end

    // R1/R2/R4/R5: matching tag with varied offsets and signed immediates.
    for (int i = 0; i < NL; i++) begin
      logic [AW-1:0] ea;
      ea = addr_of(m_tag[i], i, (i * 3) % LB);
      inval(ea - AW'(int'($signed(imms[i % 6]))), imms[i % 6], m_v[i] ? "R5 hit" : "R4 invalid miss");
      probe_chk(i, "R5 cleared");
      if (i > 0) probe_chk(i - 1, "R3 neighbour");
    end

    // R1: base just above a line, offset -100 lands in it.
    do_fill(6, TW'(300), 1'b1, 1'b1);
    inval(addr_of(TW'(300), 6, 0) + 100, 16'hFF9C, "R1 negative offset hit");
    probe_chk(6, "R1 line cleared");
    do_fill(6, TW'(300), 1'b1, 1'b0);
    inval(addr_of(TW'(300), 6, 0) - 100, 16'h0064, "R1 positive offset hit");

    // R9: fill landing on the clearing edge loses to the invalidate.
    do_fill(2, TW'(77), 1'b1, 1'b1);
    req_valid = 1'b1; req_base = addr_of(TW'(77), 2, 4); req_imm = 16'h0000;
    @(negedge clk);
    req_valid = 1'b0;
    fill_en = 1'b1; fill_idx = IW'(2); fill_tag = TW'(99); fill_valid = 1'b1; fill_dirty = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
    check("R9 hit", hit, 1);
    m_tag[2] = TW'(99); m_v[2] = 1'b0; m_d[2] = 1'b0;
    probe_chk(2, "R9 collision");

    // R8: fill on the accepting edge is seen by the lookup.
    do_fill(5, TW'(10), 1'b1, 1'b0);
    fill_en = 1'b1; fill_idx = IW'(5); fill_tag = TW'(11); fill_valid = 1'b1; fill_dirty = 1'b1;
    req_valid = 1'b1; req_base = addr_of(TW'(11), 5, 0); req_imm = 16'h0000;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check("R8 same-edge fill hit", hit, 1);
    m_tag[5] = TW'(11); m_v[5] = 1'b0; m_d[5] = 1'b0;
    probe_chk(5, "R8 same-edge result");
    fill_en = 1'b1; fill_idx = IW'(5); fill_tag = TW'(12); fill_valid = 1'b0; fill_dirty = 1'b1;
    req_valid = 1'b1; req_base = addr_of(TW'(12), 5, 0);
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    check("R4 same-edge invalid fill", hit, 0);
    m_tag[5] = TW'(12); m_v[5] = 1'b0; m_d[5] = 1'b1;
    probe_chk(5, "R4 state kept");

    // R11: probe outputs of absent cache read zero.
    check("R11 no-cache probe", pv1, 0);

    // R10: mid-run reset clears all lines.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_d[i] = 0; end
    for (int i = 0; i < NL; i++) probe_chk(i, "R10 reset sweep");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule